// File: doc/BRIEF.md
# Pause-Width Frame Transmitter

This block turns a short reader-to-card command frame into a carrier-enable waveform. A bit is sent as a symbol made of a fixed carrier-off gap and then a carrier-on stretch. A long stretch stands for a one and a short stretch for a zero. Each bit is scrambled on its way out: it is XORed with one bit taken from an external keystream source. The data is sent least significant bit first. One more carrier-off gap after the last symbol closes the frame.

A controller sets the frame bits and the bit count and pulses the start strobe. It then waits for the done pulse. The keystream arrives over a valid/take handshake, and the block takes exactly one bit for each data bit. The first frame after reset is preceded by a long carrier-on interval so the card can power up. All durations are given in microseconds and scaled by a clock-cycles-per-microsecond parameter.

Top module: `pw_frame_tx`

## Requirements
- R1: After reset, and whenever the block is not busy, `carrier_o` is 1, and `busy_o`, `done_o` and `ks_take_o` are 0.
- R2: Every symbol starts with `carrier_o` at 0 for PAUSE_US*CYC_PER_US cycles, provided a keystream bit is valid by the last cycle of that gap.
- R3: After its gap, a symbol whose sent bit is 1 keeps `carrier_o` at 1 for ONE_US*CYC_PER_US cycles. A symbol whose sent bit is 0 keeps it at 1 for ZERO_US*CYC_PER_US cycles.
- R4: Bit i of the frame is sent as `data_i[i]` XOR the i-th keystream bit taken, for i = 0 upward. `ks_take_o` pulses exactly once per data bit, only during a gap and only while `ks_valid_i` is 1. A keystream bit is taken in the cycle where both are 1.
- R5: After the last symbol, `carrier_o` is 0 for PAUSE_US*CYC_PER_US cycles. In the next cycle `carrier_o` returns to 1, `busy_o` falls and `done_o` is 1 for that single cycle.
- R6: For the first accepted start after reset, `carrier_o` stays 1 for CHARGE_US*CYC_PER_US cycles before the first gap. For every later start, the first gap begins in the cycle right after the start is sampled.
- R7: A `len_i` above MAX_BITS is treated as MAX_BITS. A `len_i` of 0 sends only the closing gap and takes no keystream bit.
- R8: A start strobe sampled while `busy_o` is 1 has no effect, whatever `data_i` and `len_i` hold at that time.
- R9: If no keystream bit has been taken by the end of a gap, the gap is stretched until `ks_valid_i` is 1. The symbol's on-time starts in the cycle after the take.
- R10: `busy_o` rises in the cycle after a start is sampled in idle and stays 1 until the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| data_i | input | MAX_BITS | Frame bits, bit 0 sent first |
| len_i | input | $clog2(MAX_BITS+1) | Number of bits to send |
| ks_valid_i | input | 1 | Keystream bit available |
| ks_bit_i | input | 1 | Keystream bit |
| ks_take_o | output | 1 | Keystream bit consumed this cycle |
| carrier_o | output | 1 | Carrier enable, 1 = carrier on |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at end of frame |

## Verification
The carrier line is a direct record of the state machine and its counter, so most internal faults show up at the first symbol after the fault. A counter reload that is off by even one cycle changes a gap or on-time width, and that is visible in the same symbol. A wrong shift or a wrong keystream pairing flips a symbol from long to short. A lost or extra take leaves the keystream count at the end of the frame different from the frame length. A stuck charge flag either drops or repeats the long power-up interval on the next frame.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHARGE = 3'd1,
    ST_GAP    = 3'd2,
    ST_MARK   = 3'd3,
    ST_CLOSE  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/pwtx_interval_timer.sv
module pwtx_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwtx_bit_shifter.sv
module pwtx_bit_shifter #(
  parameter int MAX_BITS = 11,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                adv_i,
  output logic                bit_o,
  output logic                empty_o
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BITS);

  logic [MAX_BITS-1:0] bits_q, bits_d;
  logic [LEN_W-1:0]    left_q, left_d;

  always_comb begin
    bits_d = bits_q;
    left_d = left_q;
    if (load_i) begin
      bits_d = data_i;
      left_d = (len_i > LEN_CAP) ? LEN_CAP : len_i;
    end else if (adv_i && left_q != '0) begin
      bits_d = bits_q >> 1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      left_q <= '0;
    end else begin
      bits_q <= bits_d;
      left_q <= left_d;
    end
  end

  assign bit_o   = bits_q[0];
  assign empty_o = (left_q == '0);
endmodule

// File: rtl/pwtx_key_latch.sv
module pwtx_key_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic consume_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic take_o,
  output logic avail_o,
  output logic bit_o
);
  logic have_q, have_d;
  logic key_q, key_d;

  assign take_o = en_i && !have_q && valid_i;

  always_comb begin
    have_d = have_q;
    key_d  = key_q;
    if (consume_i) begin
      have_d = 1'b0;
    end else if (take_o) begin
      have_d = 1'b1;
      key_d  = bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      key_q  <= 1'b0;
    end else begin
      have_q <= have_d;
      key_q  <= key_d;
    end
  end

  assign avail_o = have_q || valid_i;
  assign bit_o   = have_q ? key_q : bit_i;
endmodule

// File: rtl/pw_frame_tx.sv
module pw_frame_tx #(
  parameter int CYC_PER_US = 125,
  parameter int PAUSE_US   = 20,
  parameter int ONE_US     = 80,
  parameter int ZERO_US    = 40,
  parameter int CHARGE_US  = 5000,
  parameter int MAX_BITS   = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [MAX_BITS-1:0]           data_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] len_i,
  input  logic                          ks_valid_i,
  input  logic                          ks_bit_i,
  output logic                          ks_take_o,
  output logic                          carrier_o,
  output logic                          busy_o,
  output logic                          done_o
);
  import pwtx_pkg::*;

  localparam int LEN_W      = $clog2(MAX_BITS+1);
  localparam int PAUSE_CYC  = PAUSE_US  * CYC_PER_US;
  localparam int ONE_CYC    = ONE_US    * CYC_PER_US;
  localparam int ZERO_CYC   = ZERO_US   * CYC_PER_US;
  localparam int CHARGE_CYC = CHARGE_US * CYC_PER_US;
  localparam int SYM_MAX    = (ONE_CYC > ZERO_CYC) ? ONE_CYC : ZERO_CYC;
  localparam int SHORT_MAX  = (SYM_MAX > PAUSE_CYC) ? SYM_MAX : PAUSE_CYC;
  localparam int ALL_MAX    = (CHARGE_CYC > SHORT_MAX) ? CHARGE_CYC : SHORT_MAX;
  localparam int CNT_W      = $clog2(ALL_MAX + 1);

  localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(PAUSE_CYC - 1);
  localparam logic [CNT_W-1:0] ONE_LD    = CNT_W'(ONE_CYC - 1);
  localparam logic [CNT_W-1:0] ZERO_LD   = CNT_W'(ZERO_CYC - 1);
  localparam logic [CNT_W-1:0] CHARGE_LD = CNT_W'(CHARGE_CYC - 1);

  tx_state_e        st_q, st_d;
  logic             charged_q, charged_d;
  logic             carrier_q, carrier_d;
  logic             done_q, done_d;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_exp;
  logic             sh_load, sh_adv, sh_bit, sh_empty;
  logic             key_en, key_consume, key_avail, key_bit;
  logic             sym_bit;

  pwtx_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  pwtx_bit_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (sh_load),
    .data_i  (data_i),
    .len_i   (len_i),
    .adv_i   (sh_adv),
    .bit_o   (sh_bit),
    .empty_o (sh_empty)
  );

  pwtx_key_latch u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (key_en),
    .consume_i (key_consume),
    .valid_i   (ks_valid_i),
    .bit_i     (ks_bit_i),
    .take_o    (ks_take_o),
    .avail_o   (key_avail),
    .bit_o     (key_bit)
  );

  assign key_en  = (st_q == ST_GAP);
  assign sym_bit = sh_bit ^ key_bit;

  always_comb begin
    st_d        = st_q;
    charged_d   = charged_q;
    tmr_load    = 1'b0;
    tmr_val     = GAP_LD;
    sh_load     = 1'b0;
    sh_adv      = 1'b0;
    key_consume = 1'b0;
    done_d      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          sh_load  = 1'b1;
          tmr_load = 1'b1;
          if (!charged_q) begin
            st_d    = ST_CHARGE;
            tmr_val = CHARGE_LD;
          end else if (len_i == '0) begin
            st_d = ST_CLOSE;
          end else begin
            st_d = ST_GAP;
          end
        end
      end
      ST_CHARGE: begin
        if (tmr_exp) begin
          charged_d = 1'b1;
          tmr_load  = 1'b1;
          st_d      = sh_empty ? ST_CLOSE : ST_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_exp && key_avail) begin
          key_consume = 1'b1;
          sh_adv      = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = sym_bit ? ONE_LD : ZERO_LD;
          st_d        = ST_MARK;
        end
      end
      ST_MARK: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          st_d     = sh_empty ? ST_CLOSE : ST_GAP;
        end
      end
      ST_CLOSE: begin
        if (tmr_exp) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    carrier_d = !((st_d == ST_GAP) || (st_d == ST_CLOSE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      charged_q <= 1'b0;
      carrier_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      charged_q <= charged_d;
      carrier_q <= carrier_d;
      done_q    <= done_d;
    end
  end

  assign carrier_o = carrier_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
endmodule

// File: rtl/pwtx_checker.sv
module pwtx_checker #(
  parameter int PAUSE_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ks_valid_i,
  input logic ks_take_o,
  input logic carrier_o,
  input logic busy_o,
  input logic done_o
);
  localparam int RUN_W = $clog2(PAUSE_CYC + 1);

  logic [RUN_W-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_run_q <= '0;
    else if (carrier_o)
      low_run_q <= '0;
    else if (low_run_q != RUN_W'(PAUSE_CYC))
      low_run_q <= low_run_q + 1'b1;
  end

  p_idle_carrier_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (carrier_o && !ks_take_o));

  p_gap_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_o && busy_o && !$past(carrier_o)) |-> (low_run_q == RUN_W'(PAUSE_CYC)));

  p_take_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ks_take_o |-> (ks_valid_i && busy_o && !carrier_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && carrier_o && $past(busy_o) && !$past(carrier_o)));

  p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

bind pw_frame_tx pwtx_checker #(.PAUSE_CYC(PAUSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .ks_valid_i (ks_valid_i),
  .ks_take_o  (ks_take_o),
  .carrier_o  (carrier_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/pw_frame_tx_tb.sv
module pw_frame_tx_tb_top;
  localparam int CPU = 1;
  localparam int P   = 20 * CPU;
  localparam int ONE = 80 * CPU;
  localparam int ZER = 40 * CPU;
  localparam int CH  = 5000 * CPU;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [10:0] data_i;
  logic [3:0]  len_i;
  logic        ks_valid_i;
  logic        ks_bit_i;
  logic        ks_take_o, carrier_o, busy_o, done_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  int   kidx  = 0;
  int   kbase = 0;
  logic [15:0] kpat = '0;
  int   errs [1:10];

  pw_frame_tx #(.CYC_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .len_i(len_i), .ks_valid_i(ks_valid_i), .ks_bit_i(ks_bit_i),
    .ks_take_o(ks_take_o), .carrier_o(carrier_o), .busy_o(busy_o),
    .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ks_take_o) kidx <= kidx + 1;
  end

  assign ks_bit_i = kpat[(kidx - kbase) & 15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 190000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
    finish_run();
  end

  // One cycle: compare outputs at negedge, then drive inputs for the next edge.
  task automatic step(input int req, input bit ec, input bit eb, input bit ed,
                      input int t, input int kv_at, input int bs_at, input logic [10:0] d);
    if (carrier_o !== ec || busy_o !== eb || done_o !== ed) begin
      if (errs[req] == 0)
        $display("  mismatch R%0d cycle %0d: car %b/%b busy %b/%b done %b/%b",
                 req, t, carrier_o, ec, busy_o, eb, done_o, ed);
      errs[req]++;
    end
    start_i    = (t == bs_at);
    data_i     = (t == bs_at) ? ~d : d;
    ks_valid_i = (t >= kv_at);
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [10:0] d, input logic [3:0] len,
                           input logic [15:0] kp, input bit chg,
                           input int kv_at, input int bs_at);
    int eff, t, lowlen, symlen;
    bit b;
    eff = (len > 11) ? 11 : int'(len);
    for (int r = 1; r <= 10; r++) errs[r] = 0;
    @(negedge clk);
    kpat       = kp;
    kbase      = kidx;
    ks_valid_i = (kv_at <= 0);
    data_i     = d;
    len_i      = len;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 1;
    if (chg) for (int i = 0; i < CH; i++) begin step(6, 1, 1, 0, t, kv_at, bs_at, d); t++; end
    for (int i = 0; i < eff; i++) begin
      b      = d[i] ^ kp[i];
      lowlen = (i == 0 && kv_at > P) ? kv_at : P;
      symlen = b ? ONE : ZER;
      for (int k = 0; k < lowlen; k++) begin step((lowlen > P) ? 9 : 2, 0, 1, 0, t, kv_at, bs_at, d); t++; end
      for (int k = 0; k < symlen; k++) begin step(3, 1, 1, 0, t, kv_at, bs_at, d); t++; end
    end
    for (int k = 0; k < P; k++) begin step(5, 0, 1, 0, t, kv_at, bs_at, d); t++; end
    step(5, 1, 0, 1, t, kv_at, bs_at, d); t++;
    step(8, 1, 0, 0, t, kv_at, bs_at, d);
    check(kidx - kbase == eff, "R4 keystream takes", kidx - kbase, eff);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; data_i = '0; len_i = '0; ks_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    check(carrier_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0 && ks_take_o === 1'b0,
          "R1 reset state", {carrier_o, busy_o, done_o, ks_take_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(carrier_o === 1'b1 && busy_o === 1'b0, "R1 idle after reset", {carrier_o, busy_o}, 2'b10);

    // R6: first frame carries the charge interval
    run_frame(11'h5A3, 4'd11, 16'h0000, 1'b1, 0, -1);
    check(errs[6] == 0, "R6 charge interval", errs[6], 0);
    check(errs[2] == 0 && errs[3] == 0, "R2 R3 first frame", errs[2] + errs[3], 0);
    // R6: later frame starts its gap right away
    run_frame(11'h5A3, 4'd11, 16'h0000, 1'b0, 0, -1);
    check(errs[2] == 0, "R6 no second charge", errs[2], 0);

    // R3/R4 patterns at full length
    run_frame(11'h000, 4'd11, 16'h0000, 1'b0, 0, -1);
    check(errs[3] == 0, "R3 all zero bits", errs[3], 0);
    run_frame(11'h7FF, 4'd11, 16'h0000, 1'b0, 0, -1);
    check(errs[3] == 0, "R3 all one bits", errs[3], 0);
    run_frame(11'h000, 4'd11, 16'hFFFF, 1'b0, 0, -1);
    check(errs[3] == 0, "R4 key inverts", errs[3], 0);
    run_frame(11'h555, 4'd11, 16'h03A7, 1'b0, 0, -1);
    check(errs[3] == 0 && errs[2] == 0, "R4 lsb first xor", errs[3] + errs[2], 0);
    run_frame(11'h001, 4'd11, 16'h0400, 1'b0, 0, -1);
    check(errs[3] == 0, "R4 bit order ends", errs[3], 0);

    // R7: length sweep incl. zero and above max
    for (int l = 0; l < 16; l++) begin
      run_frame(11'h6B5, 4'(l), 16'h01C9, 1'b0, 0, -1);
      check(errs[2] == 0 && errs[3] == 0, "R7 length sweep symbols", errs[2] + errs[3], 0);
      check(errs[5] == 0, "R5 closing gap and done", errs[5], 0);
      check(errs[8] == 0, "R10 busy ends with done", errs[8], 0);
    end

    // R9: keystream late
    run_frame(11'h2C6, 4'd5, 16'h0013, 1'b0, 10, -1);
    check(errs[2] == 0 && errs[3] == 0, "R9 early key no effect", errs[2] + errs[3], 0);
    run_frame(11'h2C6, 4'd5, 16'h0013, 1'b0, 35, -1);
    check(errs[9] == 0 && errs[3] == 0, "R9 stretched gap", errs[9] + errs[3], 0);

    // R8: start while busy, with different data
    run_frame(11'h4D2, 4'd9, 16'h0155, 1'b0, 0, 300);
    check(errs[2] == 0 && errs[3] == 0 && errs[5] == 0, "R8 start ignored while busy",
          errs[2] + errs[3] + errs[5], 0);
    run_frame(11'h4D2, 4'd3, 16'h0155, 1'b0, 0, 5);
    check(errs[2] == 0 && errs[3] == 0 && errs[5] == 0 && errs[8] == 0,
          "R8 start in gap ignored", errs[2] + errs[3] + errs[5] + errs[8], 0);

    finish_run();
  end
endmodule